// File: doc/BRIEF.md
# Direct-Mapped Operand Data Cache

This block is a data cache that sits between a CPU load/store port and a simple memory bus that moves one 32-bit word per transfer. It has 512 lines of 32 bytes each and is direct-mapped, so each address can live in only one line. Every line keeps a 19-bit tag, a valid flag and a dirty flag. The line index comes from address bits [13:5]. The tag is physical address bits [28:10]. The physical address is taken as address bits [28:0].

Address bits [31:29] pick a region, and the region sets how a store is handled. Codes 0xx (user/P0) and 110 (P3) take their write policy from a control bit in which 1 means write-through. They can also take it from a per-page write-through attribute when address translation is on. Code 100 (kernel/P1) uses a second control bit in which 1 means copy-back. Codes 101 and 111 are never cached. A global enable bit and a per-page cacheable attribute decide whether an access uses the cache at all. An invalidate-all request sweeps every line invalid, one line per cycle.

The CPU sends a request as a one-cycle `cpuReq` pulse while `cpuReady` is high. It receives a one-cycle `cpuAck`, and for reads `cpuRdata` is valid in that cycle. The memory bus holds `memReq` until `memAck` arrives.

Top module: `opcache`

## Requirements
- R1: After reset `cpuReady` is 1, `cpuAck` is 0, `memReq` is 0, and every line is invalid, so the first read of any cached address misses. The bus stays quiet whenever `cpuReady` is 1.
- R2: A cached read miss on a clean line fetches eight word beats at ascending addresses from the 32-byte line base and returns the requested word. A later read of the same line hits with no bus traffic.
- R3: A line hits only when its stored tag equals physical bits [28:10]. Two addresses with the same bits [13:5] but different bit 14 evict each other.
- R4: In copy-back mode a write hit updates the line and sets its dirty flag with no bus write. When a dirty line is evicted, its eight words are written to its old addresses in ascending order before the new line is fetched.
- R5: A copy-back write miss first fills the line, then updates it and leaves it dirty. A later read of that word hits and returns the written value.
- R6: A write-through write hit updates the line and writes exactly one word to memory. The line stays clean, so evicting it causes no write-back.
- R7: A write-through write miss writes one word to memory and does not allocate a line. A later read of that address misses and returns the value from memory.
- R8: For region code 100, the copy-back control bit set to 1 gives copy-back and set to 0 gives write-through.
- R9: For region codes 0xx and 110, the write-through control bit set to 1 gives write-through and set to 0 gives copy-back. With translation on, the page write-through attribute replaces that bit.
- R10: With the enable bit at 0, every access is one single-word bus transfer and no line is used, even if a line holding the address is resident.
- R11: With translation on, a region 0xx/110 access is cached only if the page cacheable attribute is 1. Regions 101 and 111 are always single-word bus transfers.
- R12: An accepted invalidate-all holds `cpuReady` low for exactly 512 cycles. After it, every line is invalid and dirty data is discarded without write-back.
- R13: Once `memReq` is raised, it stays high with `memAddr`, `memWe` and `memWdata` unchanged until the cycle `memAck` is seen.
- R14: `cpuAck` is a one-cycle pulse and never occurs in the cycle right after one in which `cpuReady` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuReq | input | 1 | One-cycle request pulse, taken while cpuReady is 1 |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | Byte address of a 32-bit word |
| cpuWdata | input | 32 | Store data |
| cpuReady | output | 1 | Idle and able to accept a request |
| cpuAck | output | 1 | Access complete (one cycle) |
| cpuRdata | output | 32 | Load data, valid with cpuAck |
| cfgEnable | input | 1 | Global cache enable |
| cfgCopyBackP1 | input | 1 | Region 100 policy: 1 copy-back, 0 write-through |
| cfgWtUser | input | 1 | Region 0xx/110 policy: 1 write-through, 0 copy-back |
| xlatOn | input | 1 | Address translation active |
| pageWt | input | 1 | Page write-through attribute |
| pageCacheable | input | 1 | Page cacheable attribute |
| invalAll | input | 1 | Invalidate all lines, taken while cpuReady is 1 |
| memReq | output | 1 | Bus transfer request, held until memAck |
| memWe | output | 1 | Bus write |
| memAddr | output | 32 | Bus byte address |
| memWdata | output | 32 | Bus write data |
| memAck | input | 1 | Bus transfer done; read data valid |
| memRdata | input | 32 | Bus read data |

## Verification
The assertions assume that `memAck` is raised only while `memReq` is high and lasts one cycle per transfer. They also assume that `cpuReq` and `invalAll` arrive only while `cpuReady` is high and never in the same cycle. The control and attribute inputs are taken to matter only in the cycle a request is accepted. The bench's bus model answers each held request after one cycle and then drops its acknowledge. The bench pulses requests only after seeing `cpuReady` high, never combines a request with an invalidate, and changes policy inputs only between accesses.

// File: rtl/opcache_pkg.sv
package opcache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_EVICT,
    ST_FILL,
    ST_BUSRD,
    ST_BUSWR,
    ST_SWEEP
  } cacheState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fillBeat;    // write one fetched word into the line
    logic storeWord;   // write CPU data into the line
    logic markDirty;   // set the dirty flag of the line
    logic installTag;  // write tag, set valid, clear dirty
    logic clearLine;   // clear valid and dirty
  } dpCtl_t;

  localparam logic [2:0] REGION_KERNEL  = 3'b100;
  localparam logic [2:0] REGION_NOCACHE = 3'b101;
  localparam logic [2:0] REGION_USERHI  = 3'b110;
  localparam logic [2:0] REGION_CTRL    = 3'b111;

endpackage

// File: rtl/opcache_policy.sv
module opcache_policy
  import opcache_pkg::*;
(
  input  logic [2:0] region,
  input  logic       cfgEnable,
  input  logic       cfgCopyBackP1,
  input  logic       cfgWtUser,
  input  logic       xlatOn,
  input  logic       pageWt,
  input  logic       pageCacheable,
  output logic       useCache,
  output logic       writeThru
);
  logic isKernel, isUncached;

  always_comb begin
    isKernel   = (region == REGION_KERNEL);
    isUncached = (region == REGION_NOCACHE) || (region == REGION_CTRL);
    // page attributes only apply to translated regions
    useCache   = cfgEnable && !isUncached && (isKernel || !xlatOn || pageCacheable);
    if (isKernel)    writeThru = !cfgCopyBackP1;
    else if (xlatOn) writeThru = pageWt;
    else             writeThru = cfgWtUser;
  end
endmodule

// File: rtl/opcache_datapath.sv
module opcache_datapath
  import opcache_pkg::*;
#(
  parameter int LINES  = 512,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 19,
  localparam int IDX_W  = $clog2(LINES),
  localparam int BEAT_W = $clog2(WORDS),
  localparam int LINE_W = WORDS * DATA_W
)(
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic [IDX_W-1:0]  lineIdx,
  input  logic [BEAT_W-1:0] wordSel,
  input  logic [TAG_W-1:0]  tagIn,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] fillData,
  output logic              hit,
  output logic              victimDirty,
  output logic [TAG_W-1:0]  victimTag,
  output logic [DATA_W-1:0] wordOut
);
  logic [LINE_W-1:0] lineMem [LINES];
  logic [TAG_W-1:0]  tagMem  [LINES];
  logic [LINES-1:0]  validVec;
  logic [LINES-1:0]  dirtyVec;

  always_comb begin
    victimTag   = tagMem[lineIdx];
    hit         = validVec[lineIdx] && (victimTag == tagIn);
    victimDirty = validVec[lineIdx] && dirtyVec[lineIdx];
    wordOut     = lineMem[lineIdx][wordSel*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (ctl.fillBeat)   lineMem[lineIdx][wordSel*DATA_W +: DATA_W] <= fillData;
    if (ctl.storeWord)  lineMem[lineIdx][wordSel*DATA_W +: DATA_W] <= storeData;
    if (ctl.installTag) tagMem[lineIdx] <= tagIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validVec <= '0;
      dirtyVec <= '0;
    end else begin
      if (ctl.installTag) begin
        validVec[lineIdx] <= 1'b1;
        dirtyVec[lineIdx] <= 1'b0;
      end
      if (ctl.markDirty) dirtyVec[lineIdx] <= 1'b1;
      if (ctl.clearLine) begin
        validVec[lineIdx] <= 1'b0;
        dirtyVec[lineIdx] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/opcache_control.sv
module opcache_control
  import opcache_pkg::*;
#(
  parameter int LINES  = 512,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int PHYS_W = 29,
  parameter int TAG_LO = 10,
  localparam int IDX_W  = $clog2(LINES),
  localparam int BEAT_W = $clog2(WORDS),
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int OFF_W  = BEAT_W + BYTE_W,
  localparam int TAG_W  = PHYS_W - TAG_LO,
  localparam int LOW_W  = TAG_LO - OFF_W,
  localparam int PAD_W  = ADDR_W - PHYS_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [PHYS_W-1:0] cpuPhys,
  input  logic [DATA_W-1:0] cpuWdata,
  input  logic              useCache,
  input  logic              writeThru,
  input  logic              invalAll,
  output logic              cpuReady,
  output logic              cpuAck,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output dpCtl_t            ctl,
  output logic [IDX_W-1:0]  lineIdx,
  output logic [BEAT_W-1:0] wordSel,
  output logic [TAG_W-1:0]  tagIn,
  output logic [DATA_W-1:0] storeData,
  input  logic              hit,
  input  logic              victimDirty,
  input  logic [TAG_W-1:0]  victimTag,
  input  logic [DATA_W-1:0] wordOut
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(WORDS - 1);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(LINES - 1);

  cacheState_t       state;
  logic [PHYS_W-1:0] reqPhys;
  logic              reqWe, reqCache, reqWt;
  logic [DATA_W-1:0] reqData;
  logic [BEAT_W-1:0] beat;
  logic [IDX_W-1:0]  sweepIdx;
  logic [IDX_W-1:0]  reqIdx;

  assign reqIdx   = reqPhys[OFF_W +: IDX_W];
  assign cpuReady = (state == ST_IDLE);

  always_comb begin
    lineIdx   = (state == ST_SWEEP) ? sweepIdx : reqIdx;
    wordSel   = (state == ST_EVICT || state == ST_FILL) ? beat : reqPhys[BYTE_W +: BEAT_W];
    tagIn     = reqPhys[PHYS_W-1:TAG_LO];
    storeData = reqData;
    ctl       = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    memAddr   = {{PAD_W{1'b0}}, reqPhys};
    memWdata  = reqData;
    unique case (state)
      ST_LOOK: if (reqCache && hit && reqWe) begin
        ctl.storeWord = 1'b1;
        ctl.markDirty = !reqWt;
      end
      ST_EVICT: begin
        memReq   = 1'b1;
        memWe    = 1'b1;
        memAddr  = {{PAD_W{1'b0}}, victimTag, reqIdx[LOW_W-1:0], beat, {BYTE_W{1'b0}}};
        memWdata = wordOut;
      end
      ST_FILL: begin
        memReq         = 1'b1;
        memAddr        = {{PAD_W{1'b0}}, reqPhys[PHYS_W-1:OFF_W], beat, {BYTE_W{1'b0}}};
        ctl.fillBeat   = memAck;
        ctl.installTag = memAck && (beat == LAST_BEAT);
      end
      ST_BUSRD: memReq = 1'b1;
      ST_BUSWR: begin
        memReq = 1'b1;
        memWe  = 1'b1;
      end
      ST_SWEEP: ctl.clearLine = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cpuAck   <= 1'b0;
      cpuRdata <= '0;
      beat     <= '0;
      sweepIdx <= '0;
      reqPhys  <= '0;
      reqWe    <= 1'b0;
      reqData  <= '0;
      reqCache <= 1'b0;
      reqWt    <= 1'b0;
    end else begin
      cpuAck <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (invalAll) begin
            sweepIdx <= '0;
            state    <= ST_SWEEP;
          end else if (cpuReq) begin
            reqPhys  <= cpuPhys;
            reqWe    <= cpuWe;
            reqData  <= cpuWdata;
            reqCache <= useCache;
            reqWt    <= writeThru;
            state    <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          beat <= '0;
          if (!reqCache) begin
            state <= reqWe ? ST_BUSWR : ST_BUSRD;
          end else if (hit) begin
            if (reqWe && reqWt) begin
              state <= ST_BUSWR;
            end else begin
              if (!reqWe) cpuRdata <= wordOut;
              cpuAck <= 1'b1;
              state  <= ST_IDLE;
            end
          end else if (reqWe && reqWt) begin
            state <= ST_BUSWR;
          end else begin
            state <= victimDirty ? ST_EVICT : ST_FILL;
          end
        end
        ST_EVICT: if (memAck) begin
          beat <= beat + 1'b1;
          if (beat == LAST_BEAT) state <= ST_FILL;
        end
        ST_FILL: if (memAck) begin
          beat <= beat + 1'b1;
          if (beat == LAST_BEAT) state <= ST_LOOK;
        end
        ST_BUSRD: if (memAck) begin
          cpuRdata <= memRdata;
          cpuAck   <= 1'b1;
          state    <= ST_IDLE;
        end
        ST_BUSWR: if (memAck) begin
          cpuAck <= 1'b1;
          state  <= ST_IDLE;
        end
        ST_SWEEP: begin
          sweepIdx <= sweepIdx + 1'b1;
          if (sweepIdx == LAST_IDX) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opcache.sv
module opcache
  import opcache_pkg::*;
#(
  parameter int LINES      = 512,
  parameter int LINE_BYTES = 32,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 32,
  parameter int PHYS_W     = 29,
  parameter int TAG_LO     = 10,
  localparam int WORDS  = LINE_BYTES / (DATA_W / 8),
  localparam int IDX_W  = $clog2(LINES),
  localparam int BEAT_W = $clog2(WORDS),
  localparam int TAG_W  = PHYS_W - TAG_LO
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic              cpuReady,
  output logic              cpuAck,
  output logic [DATA_W-1:0] cpuRdata,
  input  logic              cfgEnable,
  input  logic              cfgCopyBackP1,
  input  logic              cfgWtUser,
  input  logic              xlatOn,
  input  logic              pageWt,
  input  logic              pageCacheable,
  input  logic              invalAll,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata
);
  logic              useCache, writeThru;
  dpCtl_t            ctl;
  logic [IDX_W-1:0]  lineIdx;
  logic [BEAT_W-1:0] wordSel;
  logic [TAG_W-1:0]  tagIn, victimTag;
  logic [DATA_W-1:0] storeData, wordOut;
  logic              hit, victimDirty;

  opcache_policy u_policy (
    .region(cpuAddr[ADDR_W-1 -: 3]), .cfgEnable(cfgEnable), .cfgCopyBackP1(cfgCopyBackP1),
    .cfgWtUser(cfgWtUser), .xlatOn(xlatOn), .pageWt(pageWt), .pageCacheable(pageCacheable),
    .useCache(useCache), .writeThru(writeThru)
  );

  opcache_control #(
    .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .PHYS_W(PHYS_W), .TAG_LO(TAG_LO)
  ) u_ctrl (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuPhys(cpuAddr[PHYS_W-1:0]),
    .cpuWdata(cpuWdata), .useCache(useCache), .writeThru(writeThru), .invalAll(invalAll),
    .cpuReady(cpuReady), .cpuAck(cpuAck), .cpuRdata(cpuRdata),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata),
    .ctl(ctl), .lineIdx(lineIdx), .wordSel(wordSel), .tagIn(tagIn), .storeData(storeData),
    .hit(hit), .victimDirty(victimDirty), .victimTag(victimTag), .wordOut(wordOut)
  );

  opcache_datapath #(
    .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .lineIdx(lineIdx), .wordSel(wordSel), .tagIn(tagIn),
    .storeData(storeData), .fillData(memRdata), .hit(hit), .victimDirty(victimDirty),
    .victimTag(victimTag), .wordOut(wordOut)
  );
endmodule

// File: rtl/opcache_checker.sv
module opcache_checker #(
  parameter int LINES = 512
)(
  input logic        clk,
  input logic        rst,
  input logic        cpuReady,
  input logic        cpuAck,
  input logic        invalAll,
  input logic        memReq,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic [31:0] memWdata,
  input logic        memAck
);
  localparam int CNT_W = $clog2(LINES) + 1;

  logic             swOn;
  logic [CNT_W-1:0] swCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      swOn  <= 1'b0;
      swCnt <= '0;
    end else if (!swOn && invalAll && cpuReady) begin
      swOn  <= 1'b1;
      swCnt <= '0;
    end else if (swOn) begin
      swCnt <= swCnt + 1'b1;
      if (swCnt == CNT_W'(LINES - 1)) swOn <= 1'b0;
    end
  end

  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    cpuReady |-> !memReq);                                                      // R1
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpuAck |=> !cpuAck);                                                        // R14
  AST_ACK_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    cpuAck |-> !$past(cpuReady));                                               // R14
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata))); // R13
  AST_SWEEP_BUSY: assert property (@(posedge clk) disable iff (rst)
    swOn |-> !cpuReady);                                                        // R12
  AST_SWEEP_ENDS: assert property (@(posedge clk) disable iff (rst)
    (swOn && swCnt == CNT_W'(LINES - 1)) |=> cpuReady);                         // R12
endmodule

bind opcache opcache_checker #(.LINES(LINES)) u_chk (
  .clk(clk), .rst(rst), .cpuReady(cpuReady), .cpuAck(cpuAck), .invalAll(invalAll),
  .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck)
);

// File: tb/opcache_test.sv
module opcache_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0] cpuAddr = '0, cpuWdata = '0;
  logic cpuReady, cpuAck;
  logic [31:0] cpuRdata;
  logic cfgEnable = 1'b1, cfgCopyBackP1 = 1'b1, cfgWtUser = 1'b0;
  logic xlatOn = 1'b0, pageWt = 1'b0, pageCacheable = 1'b1, invalAll = 1'b0;
  logic memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic memAck = 1'b0;
  logic [31:0] memRdata = '0;

  int checks = 0, errors = 0;
  int rdCnt = 0, wrCnt = 0, holdViol = 0;
  logic [31:0] rdLog[$];
  logic [31:0] wrLog[$];
  logic [31:0] store [logic [31:0]];
  logic prevReq = 1'b0, prevAck = 1'b0;
  logic [31:0] prevAddr = '0;

  always #5 clk = ~clk;

  opcache uut (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .cpuAck(cpuAck), .cpuRdata(cpuRdata),
    .cfgEnable(cfgEnable), .cfgCopyBackP1(cfgCopyBackP1), .cfgWtUser(cfgWtUser),
    .xlatOn(xlatOn), .pageWt(pageWt), .pageCacheable(pageCacheable), .invalAll(invalAll),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] memVal(input logic [31:0] a);
    if (store.exists(a)) return store[a];
    return pat(a);
  endfunction

  // bus model: one-cycle response per held request
  always @(posedge clk) begin
    if (prevReq && !prevAck && (!memReq || memAddr != prevAddr)) holdViol++;
    prevReq  <= memReq;
    prevAck  <= memAck;
    prevAddr <= memAddr;
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin
        store[memAddr] = memWdata;
        wrCnt++;
        wrLog.push_back(memAddr);
      end else begin
        memRdata <= memVal(memAddr);
        rdCnt++;
        rdLog.push_back(memAddr);
      end
    end else begin
      memAck <= 1'b0;
    end
  end

  task automatic chkEq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d, output logic [31:0] rd);
    int n = 0;
    @(negedge clk);
    while (!cpuReady) @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = a; cpuWdata = d;
    @(negedge clk);
    cpuReq = 1'b0;
    while (!cpuAck && n < 200) begin n++; @(negedge clk); end
    rd = cpuRdata;
    @(negedge clk);
    chkEq("R14", "ack is one cycle", {31'b0, cpuAck}, 32'h0);
  endtask

  task automatic startLog(output int r0, output int w0);
    rdLog.delete(); wrLog.delete(); r0 = rdCnt; w0 = wrCnt;
  endtask

  task automatic testReset();
    chkEq("R1", "ready after reset", {31'b0, cpuReady}, 32'h1);
    chkEq("R1", "ack after reset", {31'b0, cpuAck}, 32'h0);
    chkEq("R1", "memReq after reset", {31'b0, memReq}, 32'h0);
  endtask

  task automatic testReadMiss();
    int r0, w0; logic [31:0] rd;
    startLog(r0, w0);
    access(1'b0, 32'h0000_1234, '0, rd);
    chkEq("R2", "miss data", rd, pat(32'h1234));
    chkEq("R2", "fill beats", rdCnt - r0, 8);
    for (int k = 0; k < 8; k++) chkEq("R2", "fill order", rdLog[k], 32'h1220 + 4 * k);
    startLog(r0, w0);
    access(1'b0, 32'h0000_1228, '0, rd);
    chkEq("R2", "hit data", rd, pat(32'h1228));
    chkEq("R2", "hit bus reads", rdCnt - r0, 0);
  endtask

  task automatic testCopyBackEvict();
    int r0, w0; logic [31:0] rd;
    startLog(r0, w0);
    access(1'b1, 32'h0000_1238, 32'hC0DE_0004, rd);
    chkEq("R4", "write hit no bus", (rdCnt - r0) + (wrCnt - w0), 0);
    access(1'b0, 32'h0000_1238, '0, rd);
    chkEq("R4", "write hit readback", rd, 32'hC0DE_0004);
    startLog(r0, w0);
    access(1'b0, 32'h0000_5234, '0, rd);
    chkEq("R3", "alias misses", rdCnt - r0, 8);
    chkEq("R3", "alias data", rd, pat(32'h5234));
    chkEq("R4", "writeback beats", wrCnt - w0, 8);
    for (int k = 0; k < 8; k++) chkEq("R4", "writeback order", wrLog[k], 32'h1220 + 4 * k);
    chkEq("R4", "dirty word in memory", memVal(32'h1238), 32'hC0DE_0004);
  endtask

  task automatic testWriteAllocate();
    int r0, w0; logic [31:0] rd;
    startLog(r0, w0);
    access(1'b1, 32'h0000_2000, 32'hDEAD_0006, rd);
    chkEq("R5", "cb write miss fills", rdCnt - r0, 8);
    chkEq("R5", "cb write miss no write", wrCnt - w0, 0);
    startLog(r0, w0);
    access(1'b0, 32'h0000_2000, '0, rd);
    chkEq("R5", "readback", rd, 32'hDEAD_0006);
    chkEq("R5", "readback hits", rdCnt - r0, 0);
  endtask

  task automatic testWriteThroughHit();
    int r0, w0; logic [31:0] rd;
    cfgWtUser = 1'b1;
    access(1'b0, 32'h0000_0800, '0, rd);
    startLog(r0, w0);
    access(1'b1, 32'h0000_0804, 32'h1111_0007, rd);
    chkEq("R6", "wt hit one write", wrCnt - w0, 1);
    chkEq("R6", "wt hit memory", memVal(32'h0804), 32'h1111_0007);
    access(1'b0, 32'h0000_0804, '0, rd);
    chkEq("R6", "wt hit line updated", rd, 32'h1111_0007);
    startLog(r0, w0);
    access(1'b0, 32'h0000_4800, '0, rd);
    chkEq("R6", "clean evict no writeback", wrCnt - w0, 0);
  endtask

  task automatic testWriteThroughMiss();
    int r0, w0; logic [31:0] rd;
    startLog(r0, w0);
    access(1'b1, 32'h0000_5000, 32'h2222_0008, rd);
    chkEq("R7", "wt miss one write", wrCnt - w0, 1);
    chkEq("R7", "wt miss no fill", rdCnt - r0, 0);
    startLog(r0, w0);
    access(1'b0, 32'h0000_5000, '0, rd);
    chkEq("R7", "no allocate so miss", rdCnt - r0, 8);
    chkEq("R7", "memory value", rd, 32'h2222_0008);
    cfgWtUser = 1'b0;
  endtask

  task automatic testKernelPolicy();
    int r0, w0; logic [31:0] rd;
    cfgCopyBackP1 = 1'b1;
    startLog(r0, w0);
    access(1'b1, 32'h8000_3000, 32'h3333_0009, rd);
    chkEq("R8", "kernel cb allocates", rdCnt - r0, 8);
    chkEq("R8", "kernel cb no write", wrCnt - w0, 0);
    cfgCopyBackP1 = 1'b0;
    startLog(r0, w0);
    access(1'b1, 32'h8000_9000, 32'h4444_000A, rd);
    chkEq("R8", "kernel wt writes", wrCnt - w0, 1);
    chkEq("R8", "kernel wt no fill", rdCnt - r0, 0);
    chkEq("R8", "kernel wt phys addr", memVal(32'h0000_9000), 32'h4444_000A);
    cfgCopyBackP1 = 1'b1;
  endtask

  task automatic testPageOverride();
    int r0, w0; logic [31:0] rd;
    xlatOn = 1'b1; pageCacheable = 1'b1; cfgWtUser = 1'b0; pageWt = 1'b1;
    startLog(r0, w0);
    access(1'b1, 32'hC000_6000, 32'h5555_000B, rd);
    chkEq("R9", "page wt overrides", wrCnt - w0, 1);
    chkEq("R9", "page wt no fill", rdCnt - r0, 0);
    cfgWtUser = 1'b1; pageWt = 1'b0;
    startLog(r0, w0);
    access(1'b1, 32'hC000_6100, 32'h6666_000C, rd);
    chkEq("R9", "page cb overrides", rdCnt - r0, 8);
    chkEq("R9", "page cb no write", wrCnt - w0, 0);
    cfgWtUser = 1'b0;
  endtask

  task automatic testUncached();
    int r0, w0; logic [31:0] rd;
    pageCacheable = 1'b0;
    for (int k = 0; k < 2; k++) begin
      startLog(r0, w0);
      access(1'b0, 32'h0000_7000, '0, rd);
      chkEq("R11", "page uncached single read", rdCnt - r0, 1);
    end
    xlatOn = 1'b0; pageCacheable = 1'b1;
    for (int k = 0; k < 2; k++) begin
      startLog(r0, w0);
      access(1'b0, 32'hA000_7100, '0, rd);
      chkEq("R11", "region 101 single read", rdCnt - r0, 1);
      chkEq("R11", "region 101 data", rd, pat(32'h0000_7100));
    end
    startLog(r0, w0);
    access(1'b1, 32'hE000_0100, 32'h7777_000D, rd);
    chkEq("R11", "region 111 single write", wrCnt - w0, 1);
    chkEq("R11", "region 111 memory", memVal(32'h0000_0100), 32'h7777_000D);
  endtask

  task automatic testDisabled();
    int r0, w0; logic [31:0] rd;
    cfgEnable = 1'b0;
    startLog(r0, w0);
    access(1'b0, 32'h0000_2000, '0, rd);
    chkEq("R10", "bypass single read", rdCnt - r0, 1);
    chkEq("R10", "bypass ignores line", rd, pat(32'h2000));
    startLog(r0, w0);
    access(1'b1, 32'h0000_2004, 32'h8888_000E, rd);
    chkEq("R10", "bypass single write", wrCnt - w0, 1);
    cfgEnable = 1'b1;
  endtask

  task automatic testInvalidate();
    int r0, w0, n; logic [31:0] rd;
    @(negedge clk);
    while (!cpuReady) @(negedge clk);
    invalAll = 1'b1;
    @(negedge clk);
    invalAll = 1'b0;
    n = 0;
    while (!cpuReady && n < 2000) begin n++; @(negedge clk); end
    chkEq("R12", "sweep busy cycles", n, 512);
    startLog(r0, w0);
    access(1'b0, 32'h0000_2000, '0, rd);
    chkEq("R12", "line invalid after sweep", rdCnt - r0, 8);
    chkEq("R12", "dirty data dropped", wrCnt - w0, 0);
    chkEq("R12", "memory data", rd, pat(32'h2000));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    testReset();
    testReadMiss();
    testCopyBackEvict();
    testWriteAllocate();
    testWriteThroughHit();
    testWriteThroughMiss();
    testKernelPolicy();
    testPageOverride();
    testUncached();
    testDisabled();
    testInvalidate();
    chkEq("R13", "bus hold violations", holdViol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule